// File: doc/BRIEF.md
# Shared Instruction Translation Cache with 4 KB Granules

This block caches linear-to-physical translations for instruction fetch in one fully associative array whose entries serve both small (4 KB) and large (4 MB) pages. It never holds a large page as a single wide entry. Each entry always covers exactly one 4 KB granule. When a fetch touches a large page, only the granule that was touched is installed. A later fetch to a different granule of the same large page misses. The page walker then reads the directory entry again, treats it as a 4 KB mapping, and sends the result back to fill a fresh entry.

The fetch unit presents a linear page number on the lookup port. The registered response one cycle later gives hit, physical frame number and a flag that shows whether the entry came from a large page. After a miss, the walker writes its result on the fill port: the linear page number, the frame field of the walked entry and the page size. The flush input is pulsed when the directory base register is written. Toggling the large-page enable alone causes no flush: no such input exists, and old entries stay in force until evicted or flushed.

Top module: `code_xlate_cache`

## Requirements
- R1: After a synchronous reset every entry is invalid, `rsp_valid` is 0 and any lookup misses.
- R2: `rsp_valid` equals `lk_valid` delayed by one clock. The response reflects the array contents before the edge that samples the lookup, so a fill or flush in the same cycle does not affect it.
- R3: After a small-page fill (`fill_big`=0), a lookup of the same page number hits with `rsp_frame` equal to `fill_frame` and `rsp_big`=0.
- R4: After a large-page fill (`fill_big`=1), a lookup of the same page number hits with `rsp_big`=1. `rsp_frame` is formed from `fill_frame` bits 19:10 as its upper 10 bits and `fill_vpn` bits 9:0 as its lower 10 bits. `fill_frame` bits 9:0 are ignored.
- R5: A large-page fill covers only its own 4 KB granule. A lookup of another page number in the same 4 MB region misses until that page number is filled on its own.
- R6: On a miss `rsp_hit`, `rsp_big` and `rsp_frame` are all 0.
- R7: The array holds 32 entries. New page numbers take slots in round-robin order, so the 33rd distinct fill after a flush evicts the first one filled and keeps the other 31.
- R8: A fill whose page number is already cached overwrites that entry in place. It takes no new slot and does not move the round-robin pointer, and no page number is ever held twice.
- R9: A flush invalidates every entry. A fill in the same cycle as a flush is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Linear page number (linear bits 31:12) to translate |
| fill_valid | input | 1 | Walk result present |
| fill_vpn | input | 20 | Linear page number the walk resolved |
| fill_frame | input | 20 | Frame field of the walked entry (its bits 31:12) |
| fill_big | input | 1 | Walk ended at a 4 MB directory entry |
| flush | input | 1 | Invalidate all entries (directory base written) |
| rsp_valid | output | 1 | Response valid, one cycle after `lk_valid` |
| rsp_hit | output | 1 | Lookup found a valid entry |
| rsp_frame | output | 20 | Physical frame number on a hit, else 0 |
| rsp_big | output | 1 | Hit entry came from a 4 MB page |

## Verification
The bench fills a granule of a large page and then looks up a neighbouring granule. A design that stored large pages as wide entries would wrongly hit there. It loads 32 distinct pages, refills one that is already present and adds one more. A design that allocated duplicates, or moved the pointer on a refill, would evict the wrong page or keep two copies. Fill, lookup and flush are driven together in one cycle to expose a design whose response sees same-edge updates, or one that lets a fill survive a flush. Large-page frames are built with nonzero low frame bits, so a design that copied the walker's low bits instead of the linear granule bits returns the wrong frame.

// File: rtl/cxc_pkg.sv
package cxc_pkg;
  localparam int unsigned CXC_LIN_W   = 32;
  localparam int unsigned CXC_PAGE_SH = 12;
  localparam int unsigned CXC_BIG_SH  = 22;
  localparam int unsigned CXC_ENTRIES = 32;
endpackage

// File: rtl/cxc_match.sv
module cxc_match #(
  parameter int unsigned N  = 32,
  parameter int unsigned TW = 20,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]         vld,
  input  logic [N-1:0][TW-1:0] tags,
  input  logic [TW-1:0]        key,
  output logic [N-1:0]         vec,
  output logic                 any,
  output logic [IW-1:0]        idx
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign vec[g] = vld[g] && (tags[g] == key);
  end

  assign any = |vec;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (vec[i]) idx = idx | IW'(i);
    end
  end
endmodule

// File: rtl/cxc_victim.sv
module cxc_victim #(
  parameter int unsigned N = 32,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          adv,
  output logic [IW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (clr) ptr <= '0;
    else if (adv) ptr <= (ptr == IW'(N - 1)) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/code_xlate_cache.sv
module code_xlate_cache
  import cxc_pkg::*;
#(
  parameter int unsigned LIN_W   = CXC_LIN_W,
  parameter int unsigned PAGE_SH = CXC_PAGE_SH,
  parameter int unsigned BIG_SH  = CXC_BIG_SH,
  parameter int unsigned ENTRIES = CXC_ENTRIES,
  localparam int unsigned TAG_W  = LIN_W - PAGE_SH,
  localparam int unsigned GRN_W  = BIG_SH - PAGE_SH,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [TAG_W-1:0] lk_vpn,
  input  logic             fill_valid,
  input  logic [TAG_W-1:0] fill_vpn,
  input  logic [TAG_W-1:0] fill_frame,
  input  logic             fill_big,
  input  logic             flush,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [TAG_W-1:0] rsp_frame,
  output logic             rsp_big
);
  logic [ENTRIES-1:0]            vld_q;
  logic [ENTRIES-1:0][TAG_W-1:0] tag_q;
  logic [ENTRIES-1:0][TAG_W-1:0] frm_q;
  logic [ENTRIES-1:0]            big_q;

  logic [ENTRIES-1:0] lk_vec, fl_vec;
  logic               lk_any, fl_any;
  logic [IDX_W-1:0]   lk_idx, fl_idx, vic_ptr, slot;
  logic [TAG_W-1:0]   new_frame;
  logic               do_fill;

  cxc_match #(.N(ENTRIES), .TW(TAG_W)) u_lk_match (
    .vld(vld_q), .tags(tag_q), .key(lk_vpn),
    .vec(lk_vec), .any(lk_any), .idx(lk_idx)
  );

  cxc_match #(.N(ENTRIES), .TW(TAG_W)) u_fl_match (
    .vld(vld_q), .tags(tag_q), .key(fill_vpn),
    .vec(fl_vec), .any(fl_any), .idx(fl_idx)
  );

  assign do_fill = fill_valid && !flush;
  assign slot    = fl_any ? fl_idx : vic_ptr;

  cxc_victim #(.N(ENTRIES)) u_victim (
    .clk(clk), .clr(rst || flush), .adv(do_fill && !fl_any), .ptr(vic_ptr)
  );

  // A large page is cut to the touched granule: upper frame from the
  // directory entry, granule index from the linear page number.
  assign new_frame = fill_big ? {fill_frame[TAG_W-1:GRN_W], fill_vpn[GRN_W-1:0]}
                              : fill_frame;

  always_ff @(posedge clk) begin
    if (rst || flush) vld_q <= '0;
    else if (do_fill) vld_q[slot] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      tag_q[slot] <= fill_vpn;
      frm_q[slot] <= new_frame;
      big_q[slot] <= fill_big;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_frame <= '0;
      rsp_big   <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && lk_any;
      rsp_frame <= (lk_valid && lk_any) ? frm_q[lk_idx] : '0;
      rsp_big   <= (lk_valid && lk_any) ? big_q[lk_idx] : 1'b0;
    end
  end
endmodule

// File: rtl/cxc_checker.sv
module cxc_checker #(
  parameter int unsigned N  = 32,
  parameter int unsigned TW = 20
) (
  input logic          clk,
  input logic          rst,
  input logic          lk_valid,
  input logic          fill_valid,
  input logic          flush,
  input logic          rsp_valid,
  input logic          rsp_hit,
  input logic          rsp_big,
  input logic [TW-1:0] rsp_frame,
  input logic [N-1:0]  lk_vec,
  input logic [N-1:0]  fl_vec,
  input logic          fl_any,
  input logic [N-1:0]  vld_q
);
  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);
  p_rsp_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid);
  p_hit_needs_valid_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid);
  p_miss_clean_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_frame == '0 && !rsp_big));
  p_big_needs_hit_r4: assert property (@(posedge clk) disable iff (rst)
    rsp_big |-> rsp_hit);
  p_flush_empties_r9: assert property (@(posedge clk) disable iff (rst)
    flush |=> (vld_q == '0));
  p_after_flush_miss_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(flush) && lk_valid) |=> !rsp_hit);
  p_no_dup_lk_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_vec));
  p_no_dup_fl_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fl_vec));
  p_refill_in_place_r8: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && !flush && fl_any) |=> $countones(vld_q) == $past($countones(vld_q)));
endmodule

bind code_xlate_cache cxc_checker #(.N(ENTRIES), .TW(TAG_W)) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .fill_valid(fill_valid),
  .flush(flush), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_big(rsp_big),
  .rsp_frame(rsp_frame), .lk_vec(lk_vec), .fl_vec(fl_vec), .fl_any(fl_any),
  .vld_q(vld_q)
);

// File: tb/sim_code_xlate_cache.sv
`timescale 1ns/1ps
module sim_code_xlate_cache;
  localparam int NE = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0, fill_valid = 1'b0, fill_big = 1'b0, flush = 1'b0;
  logic [19:0] lk_vpn = '0, fill_vpn = '0, fill_frame = '0;
  logic        rsp_valid, rsp_hit, rsp_big;
  logic [19:0] rsp_frame;

  int checks = 0;
  int bad = 0;
  bit done = 0;
  bit armed = 0;

  always #10 clk = ~clk;

  code_xlate_cache u0 (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_frame(fill_frame),
    .fill_big(fill_big), .flush(flush), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_frame(rsp_frame), .rsp_big(rsp_big)
  );

  // Behavioural reference: list of cached pages in fill order plus a
  // slot ring for replacement.
  bit          m_v[NE];
  logic [19:0] m_t[NE];
  logic [19:0] m_f[NE];
  bit          m_b[NE];
  int          m_ptr = 0;
  bit          e_valid = 0, e_hit = 0, e_big = 0;
  logic [19:0] e_frame = '0;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_v[i]) m_v[i] = 0;
      m_ptr = 0;
      e_valid = 0; e_hit = 0; e_big = 0; e_frame = '0;
    end else begin
      e_valid = lk_valid; e_hit = 0; e_big = 0; e_frame = '0;
      if (lk_valid)
        foreach (m_v[i])
          if (m_v[i] && m_t[i] == lk_vpn) begin
            e_hit = 1; e_frame = m_f[i]; e_big = m_b[i];
          end
      if (flush) begin
        foreach (m_v[i]) m_v[i] = 0;
        m_ptr = 0;
      end else if (fill_valid) begin
        int at;
        at = -1;
        foreach (m_v[i]) if (m_v[i] && m_t[i] == fill_vpn) at = i;
        if (at < 0) begin
          at = m_ptr;
          m_ptr = (m_ptr + 1) % NE;
        end
        m_v[at] = 1;
        m_t[at] = fill_vpn;
        m_f[at] = fill_big ? {fill_frame[19:10], fill_vpn[9:0]} : fill_frame;
        m_b[at] = fill_big;
      end
    end
    armed = 1;
  end

  // Per-cycle comparison against the reference (R2, R3, R4, R6)
  always @(negedge clk) begin
    if (armed && !done) begin
      checks++;
      if (rsp_valid !== e_valid || rsp_hit !== e_hit || rsp_big !== e_big ||
          rsp_frame !== e_frame) begin
        bad++;
        $display("FAIL R2/R3/R4/R6 model: got v=%0b h=%0b f=%05h b=%0b exp v=%0b h=%0b f=%05h b=%0b",
                 rsp_valid, rsp_hit, rsp_frame, rsp_big, e_valid, e_hit, e_frame, e_big);
      end
    end
  end

  task automatic cyc(input bit lv, input logic [19:0] lk, input bit fv,
                     input logic [19:0] fvpn, input logic [19:0] ffrm,
                     input bit fb, input bit fl);
    lk_valid = lv; lk_vpn = lk; fill_valid = fv; fill_vpn = fvpn;
    fill_frame = ffrm; fill_big = fb; flush = fl;
    @(negedge clk);
    lk_valid = 0; fill_valid = 0; fill_big = 0; flush = 0;
  endtask

  task automatic fill(input logic [19:0] v, input logic [19:0] f, input bit b);
    cyc(0, '0, 1, v, f, b, 0);
  endtask

  task automatic expect_rsp(input string req, input bit h,
                            input logic [19:0] f, input bit b);
    checks++;
    if (rsp_valid !== 1'b1 || rsp_hit !== h || rsp_frame !== f || rsp_big !== b) begin
      bad++;
      $display("FAIL %s: got v=%0b h=%0b f=%05h b=%0b exp v=1 h=%0b f=%05h b=%0b",
               req, rsp_valid, rsp_hit, rsp_frame, rsp_big, h, f, b);
    end
  endtask

  task automatic look(input logic [19:0] v, input string req, input bit h,
                      input logic [19:0] f, input bit b);
    cyc(1, v, 0, '0, '0, 0, 0);
    expect_rsp(req, h, f, b);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      bad++;
      $display("FAIL R1: rsp_valid=%0b exp 0 in reset", rsp_valid);
    end
    rst = 0;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      bad++;
      $display("FAIL R2: rsp_valid=%0b exp 0 with no lookup", rsp_valid);
    end
    look(20'h00C03, "R1", 0, 20'h0, 0);

    // Large page granule: low walker frame bits must be replaced
    fill(20'h00C03, 20'hABC05, 1);
    look(20'h00C03, "R4", 1, 20'hABC03, 1);
    look(20'h00C04, "R5", 0, 20'h0, 0);
    fill(20'h00C04, 20'hABC05, 1);
    look(20'h00C04, "R5", 1, 20'hABC04, 1);
    look(20'h00C03, "R5", 1, 20'hABC03, 1);

    // Small page
    fill(20'h12345, 20'h87654, 0);
    look(20'h12345, "R3", 1, 20'h87654, 0);
    look(20'h12346, "R6", 0, 20'h0, 0);

    // Lookup and fill of the same page in one cycle: lookup sees old state
    cyc(1, 20'h22222, 1, 20'h22222, 20'h33333, 0, 0);
    expect_rsp("R2", 0, 20'h0, 0);
    look(20'h22222, "R2", 1, 20'h33333, 0);

    // Refill in place
    fill(20'h12345, 20'h11111, 0);
    look(20'h12345, "R8", 1, 20'h11111, 0);

    // Capacity and round-robin
    cyc(0, '0, 0, '0, '0, 0, 1);
    for (int i = 0; i < NE; i++) fill(20'h40000 + 20'(i), 20'h50000 + 20'(i), 0);
    for (int i = 0; i < NE; i++) look(20'h40000 + 20'(i), "R7", 1, 20'h50000 + 20'(i), 0);
    fill(20'h40005, 20'h6AAAA, 0);
    fill(20'h40020, 20'h5FFFF, 0);
    look(20'h40000, "R7", 0, 20'h0, 0);
    look(20'h40001, "R8", 1, 20'h50001, 0);
    look(20'h40005, "R8", 1, 20'h6AAAA, 0);
    look(20'h40020, "R7", 1, 20'h5FFFF, 0);
    look(20'h4001F, "R7", 1, 20'h5001F, 0);

    // Flush with same-cycle lookup and fill
    cyc(1, 20'h40001, 1, 20'h70000, 20'h71111, 0, 1);
    expect_rsp("R9", 1, 20'h50001, 0);
    look(20'h70000, "R9", 0, 20'h0, 0);
    look(20'h40001, "R9", 0, 20'h0, 0);
    look(20'h40020, "R9", 0, 20'h0, 0);

    // Reset clears contents
    fill(20'h0ABCD, 20'h0DCBA, 0);
    rst = 1;
    @(negedge clk);
    rst = 0;
    look(20'h0ABCD, "R1", 0, 20'h0, 0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      bad++;
      $display("FAIL watchdog: run did not finish, exp completion");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule